// File: doc/BRIEF.md
# Six-State Arm Conduction Sequencer

This block turns the running phase angle of the ac grid into the arm conduction pattern of a six-arm converter. The fundamental cycle is divided into six 60° conduction states. In each state four arms conduct: two upper and two lower. One phase has both of its arms on and carries the dc circulating path, and which phase that is advances by 60° each state. A grid synchronizer supplies an unsigned angle word that covers one full cycle, a validity flag, and a control tick (nominally 10 kHz). On every tick the sequencer decodes the angle, updates the six arm enables and the one-hot overlap code, and raises a one-cycle strobe when the conduction state changes.

The director-switch command word is reloaded only in the cycle that carries the boundary strobe, so switch transitions fall on conduction-state changes, where the arm current is zero. When the synchronizer drops its valid flag, every enable and command goes to zero. Sequencing resumes cleanly on the first valid tick after that.

Top module: `arm_sequencer`

## Requirements
- R1: On a cycle with `tick` and `syncValid` both high, the state index is captured and appears on `stateIdx` after that clock edge. The index is floor(s*6 / 2^W), where s = (phaseAngle + floor(2^W/12)) mod 2^W. With W = 16 the offset is 5461, so state 0 covers the angles around zero.
- R2: Arm enables per state, written as upper/lower with bit0 = phase A, bit1 = B, bit2 = C: state0 101/011, state1 101/110, state2 011/110, state3 011/101, state4 110/101, state5 110/011.
- R3: While a state is held, exactly two bits of `armUpper` and exactly two bits of `armLower` are set.
- R4: `overlapPhase` is one-hot while a state is held. It names the single phase whose upper and lower arms are both enabled (bit0 = A), so the sequence from state0 is A, C, B, A, C, B.
- R5: `boundaryStrobe` is high for the one cycle after a capture whose index differs from the held index. It is also high after the first capture following reset or loss of validity. It is low otherwise.
- R6: `switchCmd` = {armLower, armUpper} (bits 2:0 upper, bits 5:3 lower). It is reloaded only in the cycle where `boundaryStrobe` rises, and it is otherwise held, apart from the clearing in R8.
- R7: On cycles with `tick` low and `syncValid` high, the angle input is ignored and all outputs except the strobe hold their values.
- R8: One edge after `syncValid` is sampled low, `armUpper`, `armLower`, `overlapPhase`, `switchCmd`, `stateIdx` and `boundaryStrobe` are all zero.
- R9: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Control-tick qualifier from the synchronizer |
| syncValid | input | 1 | Synchronizer lock / angle valid |
| phaseAngle | input | 16 | Unsigned phase angle, full scale = one cycle |
| stateIdx | output | 3 | Held conduction state index 0..5 |
| armUpper | output | 3 | Upper-arm enables, bit0 = phase A |
| armLower | output | 3 | Lower-arm enables, bit0 = phase A |
| overlapPhase | output | 3 | One-hot phase in overlap |
| switchCmd | output | 6 | Director-switch commands {lower, upper} |
| boundaryStrobe | output | 1 | One-cycle pulse at a conduction-state change |

## Verification
The assertions cover the structural rules on every cycle: four arms with two per side, a one-hot overlap code, switch commands that move only with a strobe or a clear, clearing on loss of validity, holding between ticks, and strobes only after a qualified tick. What only the bench scenarios can show is that each angle lands in the right 60° state, exactly at the ends of the boundary intervals. The same goes for the exact arm pattern per state, the forward rotation of the overlap phase during a steady sweep, and the restart strobe after validity returns. Those come from a bench model driven by a sweep, random angles and directed boundary angles.

// File: rtl/arm_seq_pkg.sv
package arm_seq_pkg;

  localparam int NUM_STATES = 6;
  localparam int NUM_PHASES = 3;
  localparam int IDX_W      = $clog2(NUM_STATES);

  typedef logic [IDX_W-1:0] stateIdx_t;

  typedef struct packed {
    logic [NUM_PHASES-1:0] upper;
    logic [NUM_PHASES-1:0] lower;
  } armPattern_t;

  typedef struct packed {
    logic capture;     // qualified tick: take a new state
    logic switchLoad;  // state boundary: reload director-switch word
    logic clear;       // synchronizer not valid: drop everything
  } seqCtrl_t;

  // Conduction pattern per state; overlap phase rotates A, C, B.
  function automatic armPattern_t patternFor(stateIdx_t idx);
    armPattern_t p;
    case (idx)
      3'd0:    begin p.upper = 3'b101; p.lower = 3'b011; end
      3'd1:    begin p.upper = 3'b101; p.lower = 3'b110; end
      3'd2:    begin p.upper = 3'b011; p.lower = 3'b110; end
      3'd3:    begin p.upper = 3'b011; p.lower = 3'b101; end
      3'd4:    begin p.upper = 3'b110; p.lower = 3'b101; end
      3'd5:    begin p.upper = 3'b110; p.lower = 3'b011; end
      default: begin p.upper = 3'b000; p.lower = 3'b000; end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/arm_seq_decode.sv
module arm_seq_decode
  import arm_seq_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic [ANGLE_W-1:0] angle,
  output stateIdx_t          idx
);

  localparam longint FULL_L   = longint'(1) << ANGLE_W;
  localparam longint OFFSET_L = FULL_L / (2 * NUM_STATES);
  localparam logic [ANGLE_W-1:0] OFFSET = OFFSET_L[ANGLE_W-1:0];

  function automatic logic [ANGLE_W:0] threshold(int k);
    longint v;
    v = (longint'(k) * FULL_L + longint'(NUM_STATES - 1)) / longint'(NUM_STATES);
    return v[ANGLE_W:0];
  endfunction

  logic [ANGLE_W-1:0]    shifted;
  logic [NUM_STATES-1:1] geBits;

  assign shifted = angle + OFFSET;

  genvar k;
  generate
    for (k = 1; k < NUM_STATES; k++) begin : g_cmp
      assign geBits[k] = ({1'b0, shifted} >= threshold(k));
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int j = 1; j < NUM_STATES; j++) begin
      idx = idx + stateIdx_t'(geBits[j]);
    end
  end

endmodule

// File: rtl/arm_seq_ctrl.sv
module arm_seq_ctrl
  import arm_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      syncValid,
  input  stateIdx_t decIdx,
  input  stateIdx_t heldIdx,
  output seqCtrl_t  ctrl,
  output logic      strobeOut
);

  logic haveState;

  always_comb begin
    ctrl.clear      = !syncValid;
    ctrl.capture    = syncValid && tick;
    ctrl.switchLoad = ctrl.capture && (!haveState || (decIdx != heldIdx));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveState <= 1'b0;
      strobeOut <= 1'b0;
    end else begin
      strobeOut <= ctrl.switchLoad;
      if (ctrl.clear)        haveState <= 1'b0;
      else if (ctrl.capture) haveState <= 1'b1;
    end
  end

endmodule

// File: rtl/arm_seq_datapath.sv
module arm_seq_datapath
  import arm_seq_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ANGLE_W-1:0]    angle,
  input  seqCtrl_t              ctrl,
  output stateIdx_t             decIdx,
  output stateIdx_t             heldIdx,
  output logic [NUM_PHASES-1:0] upperEn,
  output logic [NUM_PHASES-1:0] lowerEn,
  output logic [NUM_PHASES-1:0] overlap,
  output logic [2*NUM_PHASES-1:0] switchWord
);

  armPattern_t nextPat;

  arm_seq_decode #(.ANGLE_W(ANGLE_W)) i_decode (
    .angle (angle),
    .idx   (decIdx)
  );

  assign nextPat = patternFor(decIdx);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      heldIdx    <= '0;
      upperEn    <= '0;
      lowerEn    <= '0;
      switchWord <= '0;
    end else begin
      if (ctrl.capture) begin
        heldIdx <= decIdx;
        upperEn <= nextPat.upper;
        lowerEn <= nextPat.lower;
      end
      if (ctrl.switchLoad) begin
        switchWord <= {nextPat.lower, nextPat.upper};
      end
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PHASES; p++) begin : g_ovl
      assign overlap[p] = upperEn[p] & lowerEn[p];
    end
  endgenerate

endmodule

// File: rtl/arm_sequencer.sv
module arm_sequencer
  import arm_seq_pkg::*;
#(
  parameter int ANGLE_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               syncValid,
  input  logic [ANGLE_W-1:0] phaseAngle,
  output logic [2:0]         stateIdx,
  output logic [2:0]         armUpper,
  output logic [2:0]         armLower,
  output logic [2:0]         overlapPhase,
  output logic [5:0]         switchCmd,
  output logic               boundaryStrobe
);

  seqCtrl_t  ctrl;
  stateIdx_t decIdx;
  stateIdx_t heldIdx;

  arm_seq_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .syncValid (syncValid),
    .decIdx    (decIdx),
    .heldIdx   (heldIdx),
    .ctrl      (ctrl),
    .strobeOut (boundaryStrobe)
  );

  arm_seq_datapath #(.ANGLE_W(ANGLE_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .angle      (phaseAngle),
    .ctrl       (ctrl),
    .decIdx     (decIdx),
    .heldIdx    (heldIdx),
    .upperEn    (armUpper),
    .lowerEn    (armLower),
    .overlap    (overlapPhase),
    .switchWord (switchCmd)
  );

  assign stateIdx = heldIdx;

endmodule

// File: rtl/arm_sequencer_checks.sv
module arm_sequencer_checks #(
  parameter int ANGLE_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               syncValid,
  input logic [ANGLE_W-1:0] phaseAngle,
  input logic [2:0]         stateIdx,
  input logic [2:0]         armUpper,
  input logic [2:0]         armLower,
  input logic [2:0]         overlapPhase,
  input logic [5:0]         switchCmd,
  input logic               boundaryStrobe
);

  AST_FOUR_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    (armUpper != 3'b000) |-> ($countones(armUpper) == 2 && $countones(armLower) == 2)); // R3

  AST_OVERLAP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (armUpper != 3'b000) |-> ($countones(overlapPhase) == 1)); // R4

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(switchCmd)) |-> (boundaryStrobe || switchCmd == 6'd0)); // R6

  AST_INVALID_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!syncValid) |=> (armUpper == 3'b000 && armLower == 3'b000 &&
                      switchCmd == 6'd0 && !boundaryStrobe)); // R8

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && syncValid) |=> ($stable(stateIdx) && $stable(armUpper) &&
                              $stable(armLower) && !boundaryStrobe)); // R7

  AST_STROBE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boundaryStrobe) |-> $past(tick && syncValid)); // R5

endmodule

bind arm_sequencer arm_sequencer_checks #(.ANGLE_W(ANGLE_W)) i_chk (.*);

// File: tb/test_arm_sequencer.sv
module test_arm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 6000;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tick;
  logic        syncValid;
  logic [15:0] phaseAngle;
  logic [2:0]  stateIdx;
  logic [2:0]  armUpper;
  logic [2:0]  armLower;
  logic [2:0]  overlapPhase;
  logic [5:0]  switchCmd;
  logic        boundaryStrobe;

  int testsRun = 0;
  int testsFailed = 0;

  logic [2:0] mIdx;
  logic       mHave;
  logic [2:0] mUp;
  logic [2:0] mLo;
  logic [5:0] mSw;
  logic       mStb;

  always #(CLK_PERIOD/2) clk = ~clk;

  arm_sequencer i_arm_sequencer (
    .clk            (clk),
    .rstN           (rstN),
    .tick           (tick),
    .syncValid      (syncValid),
    .phaseAngle     (phaseAngle),
    .stateIdx       (stateIdx),
    .armUpper       (armUpper),
    .armLower       (armLower),
    .overlapPhase   (overlapPhase),
    .switchCmd      (switchCmd),
    .boundaryStrobe (boundaryStrobe)
  );

  function automatic logic [2:0] refDecode(logic [15:0] a);
    int s;
    s = (int'(a) + 5461) % 65536;
    return 3'((s * 6) / 65536);
  endfunction

  function automatic logic [5:0] refPattern(logic [2:0] i);
    // {lower, upper}
    case (i)
      3'd0: return {3'b011, 3'b101};
      3'd1: return {3'b110, 3'b101};
      3'd2: return {3'b110, 3'b011};
      3'd3: return {3'b101, 3'b011};
      3'd4: return {3'b101, 3'b110};
      default: return {3'b011, 3'b110};
    endcase
  endfunction

  function automatic logic [2:0] refOverlap(logic [2:0] i);
    case (i % 3)
      3'd0: return 3'b001;
      3'd1: return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic tk, logic vl, logic [15:0] ang);
    logic [2:0] d;
    logic [5:0] p;
    if (!vl) begin
      mIdx = 0; mHave = 0; mUp = 0; mLo = 0; mSw = 0; mStb = 0;
    end else if (tk) begin
      d = refDecode(ang);
      p = refPattern(d);
      mStb = !mHave || (d != mIdx);
      mIdx = d; mHave = 1'b1;
      mUp = p[2:0]; mLo = p[5:3];
      if (mStb) mSw = p;
    end else begin
      mStb = 0;
    end
  endtask

  task automatic checkAll(logic lastValid, logic lastTick);
    if (!lastValid) begin
      check("R8 arms", {armLower, armUpper}, 0);
      check("R8 switch/strobe/idx", {switchCmd, boundaryStrobe, stateIdx}, 0);
    end else if (!lastTick) begin
      check("R7 hold", {stateIdx, armUpper, armLower}, {mIdx, mUp, mLo});
      check("R5 strobe low", boundaryStrobe, 0);
    end else begin
      check("R1 stateIdx", stateIdx, mIdx);
      check("R2 arms", {armLower, armUpper}, {mLo, mUp});
      check("R3 count", $countones(armUpper) * 4 + $countones(armLower), 10);
      check("R4 overlap", overlapPhase, refOverlap(mIdx));
      check("R5 strobe", boundaryStrobe, mStb);
    end
    check("R6 switchCmd", switchCmd, mSw);
  endtask

  task automatic driveStep(logic tk, logic vl, logic [15:0] ang);
    tick = tk; syncValid = vl; phaseAngle = ang;
    modelStep(tk, vl, ang);
    @(negedge clk);
    checkAll(vl, tk);
  endtask

  task automatic runAll();
    logic [15:0] ang;
    logic [15:0] corners [10];
    corners = '{16'd60074, 16'd60075, 16'd5461, 16'd5462, 16'd0,
                16'd65535, 16'd16384, 16'd16385, 16'd49151, 16'd38229};
    rstN = 1'b0; tick = 1'b0; syncValid = 1'b0; phaseAngle = '0;
    mIdx = 0; mHave = 0; mUp = 0; mLo = 0; mSw = 0; mStb = 0;
    repeat (3) @(negedge clk);
    check("R9 reset", {stateIdx, armUpper, armLower, overlapPhase, switchCmd, boundaryStrobe}, 0);
    rstN = 1'b1;
    // steady forward sweep: rotation through all states
    ang = 16'd0;
    for (int i = 0; i < 800; i++) begin
      driveStep(1'b1, 1'b1, ang);
      ang = ang + 16'd331;
    end
    // directed boundary angles, each after a move to a distant state
    foreach (corners[c]) begin
      driveStep(1'b1, 1'b1, corners[c] + 16'd32768);
      driveStep(1'b1, 1'b1, corners[c]);
      check("R1 corner decode", stateIdx, refDecode(corners[c]));
    end
    // validity drop then restart in the same state
    driveStep(1'b1, 1'b1, 16'd100);
    driveStep(1'b0, 1'b0, 16'd100);
    driveStep(1'b1, 1'b1, 16'd100);
    check("R5 restart strobe", boundaryStrobe, 1);
    // angle changes without tick are ignored
    driveStep(1'b0, 1'b1, 16'd30000);
    check("R7 ignored angle", stateIdx, 0);
    // constrained random
    void'($urandom(32'd4242));
    ang = 16'd0;
    for (int i = 0; i < RUN_CYCLES; i++) begin
      logic tk;
      logic vl;
      tk = ($urandom % 3) == 0;
      vl = ($urandom % 20) != 0;
      if (($urandom % 4) == 0) ang = 16'($urandom);
      else ang = ang + 16'($urandom % 2000);
      driveStep(tk, vl, ang);
    end
  endtask

  initial begin
    fork
      begin
        runAll();
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule